// File: doc/BRIEF.md
# ADC conversion control sequencer

This block is the digital controller placed in front of a successive-approximation converter core. An 8-bit control/status word holds four fields. From bit 7 down they are a read-only completion flag, an interrupt enable, a continuous-mode bit and a 5-bit channel selector. A conversion is started either by writing the control word (software trigger) or by a rising edge on a hardware trigger input (hardware trigger). The block sends the core a one-cycle start strobe together with the selected channel. It then waits for the core's done pulse and captures the result.

A qualifier input can enable compare gating. When gating is on, the completion flag is raised only if the core reports the compare as true for that conversion. The channel code of all ones switches the converter off. The block also returns to a low-power idle state by itself after every single conversion. A control write made while a conversion is running abandons that conversion and applies the new settings.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word reads 0x1F (flag, interrupt enable and continuous bit all 0, channel 11111). `low_power` is 1, `irq` is 0, and no start strobe is issued.
- R2: In software-trigger mode (`hw_trig_sel`=0), a write with continuous=0 and a channel other than 11111 makes `conv_start` high for exactly one cycle. This happens in the cycle after the write, with `conv_chan` equal to the written channel. `low_power` goes to 0 and stays 0 until the done pulse. After that the block returns to `low_power`=1 and starts nothing more.
- R3: An accepted done pulse sets the completion flag (bit 7 of `reg_rdata`) when `cmp_en`=0. When `cmp_en`=1, the flag is set only if `cmp_true` is 1 in the done cycle.
- R4: Any control write clears the flag. A `res_lo_rd` pulse also clears it, unless a done pulse is accepted in the same cycle, in which case the done pulse wins.
- R5: `irq` is 1 exactly when the completion flag and the interrupt enable (bit 6) are both 1.
- R6: With continuous=1 in software-trigger mode, the next `conv_start` follows in the cycle after each accepted done pulse, and `low_power` stays 0.
- R7: In hardware-trigger mode (`hw_trig_sel`=1), a control write starts nothing. Each rising edge of `hw_trig` seen while idle, with a channel other than 11111, starts exactly one conversion. A held-high level does not start another. A rising edge seen while a conversion is running is ignored.
- R8: In hardware-trigger mode with continuous=1, one rising edge starts conversions that repeat back to back.
- R9: Writing channel 11111 stops all activity in the next cycle. `low_power` becomes 1 and no further start is issued. A done pulse from the abandoned conversion does not set the flag.
- R10: A write while a conversion is running abandons it. It restarts according to the new word, with `conv_chan` showing the new channel, and the flag stays 0 until the new conversion finishes.
- R11: Channel codes 11100, 11101 and 11110 behave like ordinary channels: the code appears unchanged on `conv_chan` with a normal start strobe.
- R12: `result` takes the value of `conv_result` on every accepted done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 8 | Control word write data (bit 7 ignored) |
| reg_rdata | output | 8 | Control/status word |
| res_lo_rd | input | 1 | Read of the low result byte, clears the flag |
| hw_trig_sel | input | 1 | 1 = hardware trigger, 0 = software trigger |
| hw_trig | input | 1 | Hardware trigger, rising-edge sensitive |
| cmp_en | input | 1 | Compare gating of the completion flag enabled |
| cmp_true | input | 1 | Compare outcome of the finishing conversion |
| conv_start | output | 1 | One-cycle start strobe to the core |
| conv_chan | output | 5 | Channel index to the core |
| conv_done | input | 1 | Core done pulse |
| conv_result | input | RES_W | Core result |
| result | output | RES_W | Captured result |
| irq | output | 1 | Completion interrupt |
| low_power | output | 1 | 1 when no conversion is running |

## Verification
The bench targets four stopping and restarting corners:
- Writing channel 11111 during continuous operation. A design that gets this wrong issues one more conversion.
- A done pulse that arrives after an abort. A wrong design raises a spurious flag.
- A hardware trigger held high, or one that rises during a busy conversion. A wrong design retriggers.
- A compare-gated completion with a false compare. A wrong design sets the flag regardless.

Random single conversions with random interrupt enable and compare inputs also check the flag, the interrupt and the captured result against values computed in the bench.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             res_lo_rd,
  input  logic             hw_trig_sel,
  input  logic             hw_trig,
  input  logic             cmp_en,
  input  logic             cmp_true,
  output logic             conv_start,
  output logic [4:0]       conv_chan,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic [RES_W-1:0] result,
  output logic             irq,
  output logic             low_power
);
  localparam logic [4:0] CH_OFF = 5'h1F;

  logic             flag, aien, cont, busy, trig_q, start_q;
  logic [4:0]       chan;
  logic [RES_W-1:0] res_q;

  wire off     = (chan == CH_OFF);
  wire rise    = hw_trig & ~trig_q;
  wire hw_go   = hw_trig_sel & rise & ~busy & ~off;
  wire done_ok = conv_done & busy;
  wire hit     = ~cmp_en | cmp_true;
  wire sw_go   = (reg_wdata[4:0] != CH_OFF) & ~hw_trig_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      aien    <= 1'b0;
      cont    <= 1'b0;
      chan    <= CH_OFF;
      busy    <= 1'b0;
      trig_q  <= 1'b0;
      start_q <= 1'b0;
      res_q   <= '0;
    end else begin
      trig_q  <= hw_trig;
      start_q <= 1'b0;
      if (reg_wr) begin
        {aien, cont, chan} <= reg_wdata[6:0];
        flag    <= 1'b0;
        busy    <= sw_go;
        start_q <= sw_go;
      end else begin
        if (res_lo_rd) flag <= 1'b0;
        if (done_ok) begin
          res_q <= conv_result;
          if (hit) flag <= 1'b1;
          if (cont) start_q <= 1'b1;
          else busy <= 1'b0;
        end else if (hw_go) begin
          busy    <= 1'b1;
          start_q <= 1'b1;
        end
      end
    end
  end

  assign reg_rdata  = {flag, aien, cont, chan};
  assign conv_start = start_q;
  assign conv_chan  = chan;
  assign result     = res_q;
  assign irq        = flag & aien;
  assign low_power  = ~busy;

  assert_start_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (!low_power && conv_chan != CH_OFF));
  assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !low_power && !reg_wr && !cmp_en) |=> reg_rdata[7]);
  assert_flag_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !low_power && !reg_wr && cmp_en && !cmp_true && !reg_rdata[7]) |=> !reg_rdata[7]);
  assert_write_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_rdata[7]);
  assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (reg_rdata[7] && reg_rdata[6]));
  assert_off_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[4:0] == CH_OFF) |=> (low_power && !conv_start));
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
  localparam int RES_W = 12;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, res_lo_rd = 0, hw_trig_sel = 0, hw_trig = 0, cmp_en = 0, cmp_true = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic conv_start, conv_done = 0, irq, low_power;
  logic [4:0] conv_chan;
  logic [RES_W-1:0] conv_result = 0, result;
  int checks = 0, fails = 0, starts = 0, lat = 3, cnt = 0;
  logic [RES_W-1:0] core_last = 0;

  always #4 clk = ~clk;

  adc_seq_ctrl #(.RES_W(RES_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .res_lo_rd(res_lo_rd), .hw_trig_sel(hw_trig_sel), .hw_trig(hw_trig), .cmp_en(cmp_en),
    .cmp_true(cmp_true), .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_result(conv_result), .result(result), .irq(irq), .low_power(low_power));

  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (conv_start) starts <= starts + 1;
    if (!rst_n) cnt <= 0;
    else if (conv_start) cnt <= lat;
    else if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        logic [RES_W-1:0] v;
        v = RES_W'($urandom);
        conv_done <= 1'b1;
        conv_result <= v;
        core_last <= v;
      end
    end
  end

  function automatic logic exp_flag(logic ce, logic ct);
    return !ce || ct;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic wait_done();
    while (!conv_done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int s0;
    void'($urandom(32'h5eed));
    idle(3); rst_n = 1; idle(2);
    check("R1 rdata", reg_rdata, 8'h1F);
    check("R1 low_power", low_power, 1);
    check("R1 irq", irq, 0);
    check("R1 starts", starts, 0);

    s0 = starts;
    wr(8'h43);
    check("R2 start", conv_start, 1);
    check("R2 chan", conv_chan, 3);
    check("R2 busy", low_power, 0);
    idle(1);
    check("R2 one pulse", conv_start, 0);
    wait_done();
    check("R3 flag", reg_rdata[7], 1);
    check("R5 irq", irq, 1);
    check("R12 result", result, core_last);
    check("R2 low_power", low_power, 1);
    idle(20);
    check("R2 single", starts - s0, 1);

    @(negedge clk); res_lo_rd = 1; @(negedge clk); res_lo_rd = 0;
    check("R4 read clears", reg_rdata[7], 0);
    check("R5 irq low", irq, 0);

    cmp_en = 1; cmp_true = 0;
    wr(8'h42); wait_done();
    check("R3 gated false", reg_rdata[7], 0);
    cmp_true = 1;
    wr(8'h42); wait_done();
    check("R3 gated true", reg_rdata[7], 1);
    wr(8'h02);
    check("R4 write clears", reg_rdata[7], 0);
    wait_done();
    check("R5 ie off", irq, 0);
    cmp_en = 0;

    lat = 6;
    wr(8'h42);
    while (!conv_done) @(negedge clk);
    res_lo_rd = 1; @(negedge clk); res_lo_rd = 0;
    check("R4 done beats read", reg_rdata[7], 1);

    wr(8'h25);
    for (int i = 0; i < 3; i++) begin
      wait_done();
      check("R6 restart", conv_start, 1);
      check("R6 busy", low_power, 0);
    end
    wr(8'h3F);
    check("R9 low_power", low_power, 1);
    s0 = starts; idle(20);
    check("R9 no extra", starts - s0, 0);
    check("R9 flag", reg_rdata[7], 0);

    wr(8'h02); idle(2);
    wr(8'h07);
    check("R10 restart", conv_start, 1);
    check("R10 chan", conv_chan, 7);
    check("R10 flag", reg_rdata[7], 0);
    wait_done();
    check("R10 done", reg_rdata[7], 1);
    wr(8'h04); idle(1);
    wr(8'h1F); idle(20);
    check("R9 stale done", reg_rdata[7], 0);

    hw_trig_sel = 1;
    s0 = starts;
    wr(8'h04); idle(5);
    check("R7 write no start", starts - s0, 0);
    check("R7 idle", low_power, 1);
    @(negedge clk); hw_trig = 1; idle(2);
    check("R7 trig start", starts - s0, 1);
    wait_done(); idle(20);
    check("R7 held level", starts - s0, 1);
    hw_trig = 0; idle(1); hw_trig = 1; idle(2);
    hw_trig = 0; idle(1); hw_trig = 1;
    wait_done(); idle(10);
    check("R7 busy edge ignored", starts - s0, 2);
    hw_trig = 0;
    wr(8'h24); idle(3);
    check("R8 no start on write", starts - s0, 2);
    hw_trig = 1;
    for (int i = 0; i < 3; i++) begin
      wait_done();
      check("R8 back to back", conv_start, 1);
    end
    hw_trig = 0;
    wr(8'h3F); idle(20);
    check("R9 hw stop", low_power, 1);
    hw_trig_sel = 0;

    for (int c = 28; c < 31; c++) begin
      wr(8'(c));
      check("R11 chan", conv_chan, c);
      check("R11 start", conv_start, 1);
      wait_done();
    end

    for (int i = 0; i < 40; i++) begin
      logic [4:0] ch;
      logic ie;
      ch = 5'($urandom_range(0, 30));
      ie = 1'($urandom);
      cmp_en = 1'($urandom); cmp_true = 1'($urandom);
      lat = $urandom_range(2, 9);
      wr({1'b0, ie, 1'b0, ch});
      check("R2 rnd chan", conv_chan, ch);
      wait_done();
      check("R3 rnd flag", reg_rdata[7], exp_flag(cmp_en, cmp_true));
      check("R5 rnd irq", irq, ie & exp_flag(cmp_en, cmp_true));
      check("R12 rnd result", result, core_last);
    end
    finish_run();
  end
endmodule